// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the purely combinational arithmetic and logic unit that sits behind the accumulator of a small 8-bit controller core. In one pass it takes the accumulator value, a second operand, the current carry and auxiliary-carry flags, and a 4-bit operation code. It returns the next accumulator value, the next carry and auxiliary-carry values, and two write strobes. The strobes tell the flag register which of the two flags this operation owns.

The operations are binary add with and without carry-in, the three bitwise logic operations, increment, decrement, clear, complement, plain and through-carry rotates in both directions, a nibble exchange, and a packed-BCD decimal adjust. Decimal adjust corrects the value in two stages, low digit first and then high digit. Its carry only ever moves from 0 to 1. When an operation does not write a flag, the flag output carries the input flag through unchanged, so the surrounding core can load both flags on every operation if it chooses.

Top module: `acc_alu`

## Requirements
- R1: The operation code `op_i` selects: 0 add, 1 add with carry, 2 AND, 3 OR, 4 XOR, 5 increment, 6 decrement, 7 clear, 8 complement, 9 rotate left, 10 rotate right, 11 rotate left through carry, 12 rotate right through carry, 13 nibble swap, 14 decimal adjust, 15 hold (`acc_o` equals `a_i`, and neither write strobe is set).
- R2: Add gives `acc_o` = (a + b + cin) mod 256, where cin is 0 for code 0 and `c_i` for code 1. `c_o` is 1 exactly when that sum exceeds 255.
- R3: For both add codes, `ac_o` is 1 exactly when a[3:0] + b[3:0] + cin exceeds 15.
- R4: `c_we_o` is 1 only for codes 0, 1, 11, 12 and 14, and `ac_we_o` is 1 only for codes 0 and 1. Whenever a strobe is 0, the matching flag output equals its input flag.
- R5: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of `a_i` and `b_i`.
- R6: Increment and decrement wrap modulo 256 (0xFF+1 gives 0x00, and 0x00-1 gives 0xFF). Clear gives 0x00. Complement gives the bitwise inverse of `a_i`.
- R7: Rotate left moves bit 7 to bit 0, and rotate right moves bit 0 to bit 7. Swap exchanges bits [7:4] with bits [3:0].
- R8: Rotate left through carry puts `c_i` into bit 0 and old bit 7 into `c_o`. Rotate right through carry puts `c_i` into bit 7 and old bit 0 into `c_o`.
- R9: Decimal adjust, first stage: 6 is added when `ac_i` is 1 or a[3:0] is greater than 9.
- R10: Decimal adjust, second stage: 0x60 is added to the first-stage result when `c_i` is 1, or the first stage overflowed past 0xFF, or the first-stage result is greater than 0x99.
- R11: Decimal adjust sets `c_o` when `c_i` is 1 or when either stage overflows past 0xFF, and it never clears it. `ac_o` equals `ac_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator value |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| acc_o | output | 8 | Next accumulator value |
| c_o | output | 1 | Next carry flag |
| ac_o | output | 1 | Next auxiliary-carry flag |
| c_we_o | output | 1 | Carry flag write strobe |
| ac_we_o | output | 1 | Auxiliary-carry flag write strobe |

## Verification
The hardest case to reach is a decimal adjust where the first stage carries out of bit 7. This happens only for values near 0xFA–0xFF with the low-digit fix applied. In that case the second stage adds 0x60 to a small wrapped value and produces no carry of its own, so the carry has to come from the first stage. No arithmetic sequence in a real program is needed to get there, because the bench drives every accumulator value under all four flag combinations for every operation code. It also pins 0xFA and 0x9A to literal expected results, and checks each result against an arithmetic model that builds the correction from digit comparisons.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned ALU_W = 8;
  localparam int unsigned NIB_W = ALU_W / 2;
  localparam int unsigned OP_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_CLR  = 4'd7,
    OP_CPL  = 4'd8,
    OP_RL   = 4'd9,
    OP_RR   = 4'd10,
    OP_RLC  = 4'd11,
    OP_RRC  = 4'd12,
    OP_SWAP = 4'd13,
    OP_DA   = 4'd14,
    OP_HOLD = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    ROT_L  = 2'd0,
    ROT_R  = 2'd1,
    ROT_LC = 2'd2,
    ROT_RC = 2'd3
  } rot_kind_e;
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int unsigned W  = 8,
  parameter int unsigned NW = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         hcout_o
);
  logic [W:0]  full_sum;
  logic [NW:0] half_sum;

  always_comb begin
    full_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    half_sum = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + {{NW{1'b0}}, cin_i};
  end

  assign sum_o   = full_sum[W-1:0];
  assign cout_o  = full_sum[W];
  assign hcout_o = half_sum[NW];
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
  parameter int unsigned W  = 8,
  parameter int unsigned NW = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic         c_i,
  input  logic         ac_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam logic [NW-1:0] DIGIT_MAX = NW'(9);
  localparam logic [W-1:0]  LOW_ADJ   = W'(6);
  localparam logic [W-1:0]  HIGH_ADJ  = W'(6) << NW;
  localparam logic [W-1:0]  UPPER_LIM = (W'(9) << NW) | W'(9);

  logic [W:0] stage1;
  logic [W:0] stage2;
  logic       low_fix;
  logic       high_fix;
  logic       carry1;

  always_comb begin
    low_fix  = ac_i | (a_i[NW-1:0] > DIGIT_MAX);
    stage1   = {1'b0, a_i} + {1'b0, (low_fix ? LOW_ADJ : '0)};
    carry1   = c_i | stage1[W];
    high_fix = carry1 | (stage1[W-1:0] > UPPER_LIM);
    stage2   = {1'b0, stage1[W-1:0]} + {1'b0, (high_fix ? HIGH_ADJ : '0)};
  end

  assign res_o = stage2[W-1:0];
  assign c_o   = carry1 | stage2[W];
endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  rot_kind_e    kind_i,
  input  logic [W-1:0] a_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  always_comb begin
    res_o = a_i;
    c_o   = c_i;
    case (kind_i)
      ROT_L:  res_o = {a_i[W-2:0], a_i[W-1]};
      ROT_R:  res_o = {a_i[0], a_i[W-1:1]};
      ROT_LC: begin
        res_o = {a_i[W-2:0], c_i};
        c_o   = a_i[W-1];
      end
      ROT_RC: begin
        res_o = {c_i, a_i[W-1:1]};
        c_o   = a_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [ALU_W-1:0] a_i,
  input  logic [ALU_W-1:0] b_i,
  input  logic             c_i,
  input  logic             ac_i,
  output logic [ALU_W-1:0] acc_o,
  output logic             c_o,
  output logic             ac_o,
  output logic             c_we_o,
  output logic             ac_we_o
);
  alu_op_e          op;
  logic             add_cin;
  logic [ALU_W-1:0] add_sum;
  logic             add_cout;
  logic             add_hcout;
  logic [ALU_W-1:0] da_res;
  logic             da_c;
  rot_kind_e        rot_kind;
  logic [ALU_W-1:0] rot_res;
  logic             rot_c;

  assign op      = alu_op_e'(op_i);
  assign add_cin = (op == OP_ADDC) & c_i;

  acc_alu_adder #(.W(ALU_W), .NW(NIB_W)) u_adder (
    .a_i(a_i), .b_i(b_i), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout), .hcout_o(add_hcout)
  );

  acc_alu_decadj #(.W(ALU_W), .NW(NIB_W)) u_decadj (
    .a_i(a_i), .c_i(c_i), .ac_i(ac_i),
    .res_o(da_res), .c_o(da_c)
  );

  always_comb begin
    case (op)
      OP_RR:   rot_kind = ROT_R;
      OP_RLC:  rot_kind = ROT_LC;
      OP_RRC:  rot_kind = ROT_RC;
      default: rot_kind = ROT_L;
    endcase
  end

  acc_alu_rotate #(.W(ALU_W)) u_rotate (
    .kind_i(rot_kind), .a_i(a_i), .c_i(c_i),
    .res_o(rot_res), .c_o(rot_c)
  );

  always_comb begin
    acc_o   = a_i;
    c_o     = c_i;
    ac_o    = ac_i;
    c_we_o  = 1'b0;
    ac_we_o = 1'b0;
    case (op)
      OP_ADD, OP_ADDC: begin
        acc_o   = add_sum;
        c_o     = add_cout;
        ac_o    = add_hcout;
        c_we_o  = 1'b1;
        ac_we_o = 1'b1;
      end
      OP_AND:  acc_o = a_i & b_i;
      OP_OR:   acc_o = a_i | b_i;
      OP_XOR:  acc_o = a_i ^ b_i;
      OP_INC:  acc_o = a_i + ALU_W'(1);
      OP_DEC:  acc_o = a_i - ALU_W'(1);
      OP_CLR:  acc_o = '0;
      OP_CPL:  acc_o = ~a_i;
      OP_RL, OP_RR: acc_o = rot_res;
      OP_RLC, OP_RRC: begin
        acc_o  = rot_res;
        c_o    = rot_c;
        c_we_o = 1'b1;
      end
      OP_SWAP: acc_o = {a_i[NIB_W-1:0], a_i[ALU_W-1:NIB_W]};
      OP_DA: begin
        acc_o  = da_res;
        c_o    = da_c;
        c_we_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic [OP_W-1:0]  op_i,
  input logic [ALU_W-1:0] a_i,
  input logic             c_i,
  input logic             ac_i,
  input logic [ALU_W-1:0] acc_o,
  input logic             c_o,
  input logic             ac_o,
  input logic             c_we_o,
  input logic             ac_we_o
);
  always_comb begin
    if (op_i == 4'd15) AST_HOLD_PASS: assert (acc_o == a_i && !c_we_o && !ac_we_o) else $error("hold op altered state"); // R1
    if (ac_we_o) AST_AC_ONLY_ADD: assert (op_i == 4'd0 || op_i == 4'd1) else $error("aux carry strobe on non-add"); // R4
    if (!c_we_o) AST_C_UNTOUCHED: assert (c_o == c_i) else $error("carry changed without strobe"); // R4
    if (!ac_we_o) AST_AC_UNTOUCHED: assert (ac_o == ac_i) else $error("aux carry changed without strobe"); // R4
    if (op_i == 4'd7) AST_CLR_ZERO: assert (acc_o == '0) else $error("clear not zero"); // R6
    if (op_i == 4'd9 || op_i == 4'd10 || op_i == 4'd13) AST_ROT_BITS_KEPT: assert ($countones(acc_o) == $countones(a_i)) else $error("rotate lost bits"); // R7
    if (op_i == 4'd11) AST_RLC_CARRY: assert (c_o == a_i[ALU_W-1] && acc_o[0] == c_i) else $error("rlc carry path"); // R8
    if (op_i == 4'd12) AST_RRC_CARRY: assert (c_o == a_i[0] && acc_o[ALU_W-1] == c_i) else $error("rrc carry path"); // R8
    if (op_i == 4'd14 && c_i) AST_DA_STICKY: assert (c_o) else $error("decimal adjust cleared carry"); // R11
  end
endmodule

bind acc_alu acc_alu_chk u_chk (
  .op_i(op_i), .a_i(a_i), .c_i(c_i), .ac_i(ac_i),
  .acc_o(acc_o), .c_o(c_o), .ac_o(ac_o),
  .c_we_o(c_we_o), .ac_we_o(ac_we_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic       clk;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] a, b;
  logic       cin, acin;
  logic [7:0] acc;
  logic       cout, acout, cwe, acwe;
  int         n_tests = 0;
  int         n_fail  = 0;
  int         cycles  = 0;

  acc_alu u_dut (
    .op_i(op), .a_i(a), .b_i(b), .c_i(cin), .ac_i(acin),
    .acc_o(acc), .c_o(cout), .ac_o(acout), .c_we_o(cwe), .ac_we_o(acwe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic string tag_of(input int o);
    case (o)
      0, 1:       return "R2";
      2, 3, 4:    return "R5";
      5, 6, 7, 8: return "R6";
      9, 10, 13:  return "R7";
      11, 12:     return "R8";
      14:         return "R11";
      default:    return "R1";
    endcase
  endfunction

  // returns {acc[7:0], c, ac, c_we, ac_we}
  function automatic logic [11:0] model(input int o, input int av, input int bv,
                                        input int cv, input int acv);
    int r, c2, ac2, we_c, we_ac, ci, lo;
    r = av; c2 = cv; ac2 = acv; we_c = 0; we_ac = 0;
    case (o)
      0, 1: begin
        ci = (o == 1) ? cv : 0;
        r = av + bv + ci;
        c2 = (r > 255) ? 1 : 0;
        ac2 = ((av % 16) + (bv % 16) + ci > 15) ? 1 : 0;
        r = r % 256; we_c = 1; we_ac = 1;
      end
      2: r = av & bv;
      3: r = av | bv;
      4: r = av ^ bv;
      5: r = (av + 1) % 256;
      6: r = (av + 255) % 256;
      7: r = 0;
      8: r = 255 - av;
      9: r = (av * 2) % 256 + av / 128;
      10: r = av / 2 + (av % 2) * 128;
      11: begin r = (av * 2) % 256 + cv; c2 = av / 128; we_c = 1; end
      12: begin r = av / 2 + cv * 128; c2 = av % 2; we_c = 1; end
      13: r = (av % 16) * 16 + av / 16;
      14: begin
        we_c = 1;
        lo = av % 16;
        if (acv == 1 || lo >= 10) r = r + 6;
        if (r >= 256) begin c2 = 1; r = r - 256; end
        if (c2 == 1 || r / 16 >= 10 || (r / 16 == 9 && r % 16 >= 10)) r = r + 96;
        if (r >= 256) begin c2 = 1; r = r - 256; end
      end
      default: ;
    endcase
    return {r[7:0], c2[0], ac2[0], we_c[0], we_ac[0]};
  endfunction

  task automatic apply_check(input int o, input int av, input int bv, input int cv,
                             input int acv, input string tag);
    logic [11:0] exp_v, got_v;
    op = o[3:0]; a = av[7:0]; b = bv[7:0]; cin = cv[0]; acin = acv[0];
    #1;
    exp_v = model(o, av, bv, cv, acv);
    got_v = {acc, cout, acout, cwe, acwe};
    n_tests = n_tests + 1;
    if (got_v !== exp_v) begin
      n_fail = n_fail + 1;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0d ac=%0d: actual %03h expected %03h",
               tag, o, av, bv, cv, acv, got_v, exp_v);
    end
    #1;
  endtask

  task automatic lit_check(input int o, input int av, input int bv, input int cv,
                           input int acv, input logic [11:0] exp_v, input string tag);
    logic [11:0] got_v;
    op = o[3:0]; a = av[7:0]; b = bv[7:0]; cin = cv[0]; acin = acv[0];
    #1;
    got_v = {acc, cout, acout, cwe, acwe};
    n_tests = n_tests + 1;
    if (got_v !== exp_v) begin
      n_fail = n_fail + 1;
      $display("FAIL %s op=%0d a=%02h: actual %03h expected %03h", tag, o, av, got_v, exp_v);
    end
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    op = '0; a = '0; b = '0; cin = 1'b0; acin = 1'b0;
    #20 rst_n = 1'b1;
    // quiescent inputs: add of zeros
    lit_check(0, 8'h00, 8'h00, 0, 0, {8'h00, 1'b0, 1'b0, 1'b1, 1'b1}, "R2");
    // literal corners
    lit_check(0, 8'hFF, 8'h01, 0, 0, {8'h00, 1'b1, 1'b1, 1'b1, 1'b1}, "R2");
    lit_check(1, 8'h08, 8'h07, 1, 0, {8'h10, 1'b0, 1'b1, 1'b1, 1'b1}, "R3");
    lit_check(5, 8'hFF, 8'h00, 1, 1, {8'h00, 1'b1, 1'b1, 1'b0, 1'b0}, "R6");
    lit_check(6, 8'h00, 8'h00, 0, 0, {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0}, "R6");
    lit_check(13, 8'h3C, 8'h00, 0, 0, {8'hC3, 1'b0, 1'b0, 1'b0, 1'b0}, "R7");
    lit_check(11, 8'h80, 8'h00, 1, 0, {8'h01, 1'b1, 1'b0, 1'b1, 1'b0}, "R8");
    lit_check(14, 8'h0A, 8'h00, 0, 0, {8'h10, 1'b0, 1'b0, 1'b1, 1'b0}, "R9");
    lit_check(14, 8'h9A, 8'h00, 0, 0, {8'h00, 1'b1, 1'b0, 1'b1, 1'b0}, "R10");
    lit_check(14, 8'hFA, 8'h00, 0, 0, {8'h60, 1'b1, 1'b0, 1'b1, 1'b0}, "R11");
    lit_check(14, 8'h12, 8'h00, 1, 1, {8'h78, 1'b1, 1'b1, 1'b1, 1'b0}, "R11");
    lit_check(15, 8'h5A, 8'hFF, 1, 0, {8'h5A, 1'b1, 1'b0, 1'b0, 1'b0}, "R1");
    lit_check(2, 8'hF0, 8'h3C, 0, 1, {8'h30, 1'b0, 1'b1, 1'b0, 1'b0}, "R4");
    // sweep: every op, every accumulator value, all flag pairs, spread of operands
    for (int o = 0; o < 16; o++)
      for (int av = 0; av < 256; av++)
        for (int f = 0; f < 4; f++)
          for (int bv = 0; bv < 256; bv += 17)
            apply_check(o, av, bv, f / 2, f % 2, tag_of(o));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule